// File: doc/BRIEF.md
# Sixteen-Point Streaming FFT (Delay-Feedback Pipeline)

This block computes a 16-point forward discrete Fourier transform on a continuous stream of complex fixed-point samples. Samples enter one per accepted handshake in natural time order. Transform bins leave one per handshake in bit-reversed bin order. The datapath is four decimation-in-frequency radix-2 stages, and each stage keeps half of its butterfly group in a feedback delay line. The delay lengths fall from 8 through 4 and 2 to 1. A rotation by a twiddle factor sits between each stage and the next. Where the rotation is trivial (unity or -j), no multiplier is used.

The pipeline advances only when a sample is accepted. Gaps on the input side therefore cost nothing but time. Back-pressure follows a single-register rule: `in_ready` is high whenever the output holds nothing, or when the consumer takes the held bin in the same cycle. While `out_valid` is high and `out_ready` is low, the held bin stays frozen and no input is taken. The last bins of a frame only come out as the following samples are pushed in. To drain a final frame, a user appends two frames of zeros.

Words are 9-bit two's complement with 7 fractional bits, so the range is [-2, 2). Twiddles are 10-bit words with 9 fractional bits. There is no scaling between stages. Callers keep the input small enough that a 16-fold gain stays within range.

Top module: `sdf_fft16`

## Requirements
- R1: A sample is taken at a rising clock edge when `in_valid` and `in_ready` are both high. `in_ready` equals `!out_valid || out_ready` at all times.
- R2: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_re`, `out_im` and `out_sof` hold their values into the next cycle.
- R3: The pipeline moves only on accepted samples. The first bin becomes valid in the cycle after the 19th accepted sample, and never earlier. Once a bin is taken, `out_valid` stays low until another sample is accepted.
- R4: Output slot s of a frame carries bin k, where k is s with its 4 bits reversed. For example, slot 1 carries bin 8 and slot 8 carries bin 1. An impulse at sample 8 gives +A in slots 0 to 7 and -A in slots 8 to 15.
- R5: `out_sof` is high with a valid output exactly on slot 0 (bin 0) of each frame, and low otherwise.
- R6: A unity twiddle passes data unchanged, and a -j twiddle swaps the real and imaginary parts and negates one of them. An impulse of value A at sample 0 therefore yields A in every bin exactly. A constant input c yields 16c in bin 0 and exact zeros in all other bins.
- R7: No butterfly sum, difference or rotated value wraps. Results above +255 LSB clamp to +255, and results below -256 clamp to -256. A constant (+20, -20) LSB input gives bin 0 = (255, -256).
- R8: For random inputs whose components lie within ±10 LSB, every bin component lies within 20 LSB of the exact DFT of those inputs. Each frame's signal-to-quantization-noise ratio is at least 15 dB. Products are truncated toward minus infinity right after the multiplier.
- R9: During reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Block can take the sample this cycle |
| in_re | input | 9 | Sample real part, signed, 7 fractional bits |
| in_im | input | 9 | Sample imaginary part, signed, 7 fractional bits |
| out_valid | output | 1 | Output bin present |
| out_ready | input | 1 | Consumer takes the bin this cycle |
| out_re | output | 9 | Bin real part, signed, 7 fractional bits |
| out_im | output | 9 | Bin imaginary part, signed, 7 fractional bits |
| out_sof | output | 1 | Marks slot 0 (bin 0) of a frame |

## Verification
Latency is counted in accepted samples, not in clock cycles. Slot s of frame f becomes due once the accepted-sample count reaches 16f + 19 + s. The first bin must show up right after the 19th acceptance. The bench drives its inputs at the falling edge and predicts which handshakes the next rising edge will complete. It then pairs each output handshake with the next expected bin from its own queue, so gaps and stalls never shift which bin is compared. A held output is compared one cycle later against the values recorded during the stall.

// File: rtl/sdf_fft_pkg.sv
package sdf_fft_pkg;

  localparam int NPT   = 16;
  localparam int LOG2N = $clog2(NPT);
  localparam int DW    = 9;
  localparam int TW    = 10;
  localparam int TFW   = TW - 1;
  localparam int KW    = LOG2N - 1;
  localparam int DMAX  = (1 << (DW - 1)) - 1;
  localparam int DMIN  = -(1 << (DW - 1));
  localparam int FILL  = NPT - 1 + LOG2N;

  typedef logic signed [DW-1:0] dword_t;
  typedef logic signed [TW-1:0] tword_t;

  typedef struct packed {
    dword_t re;
    dword_t im;
  } cplx_t;

  typedef enum logic [1:0] {ROT_NONE, ROT_SWAP, ROT_FULL} rot_kind_e;

  function automatic dword_t sat_dw(input int v);
    if (v > DMAX) return dword_t'(DMAX);
    if (v < DMIN) return dword_t'(DMIN);
    return dword_t'(v);
  endfunction

  // multiply by -j: (re, im) -> (im, -re)
  function automatic cplx_t neg_j(input cplx_t a);
    cplx_t r;
    r.re = a.im;
    r.im = sat_dw(-int'(a.re));
    return r;
  endfunction

  // real part of W16^k, scaled by 2^TFW
  function automatic tword_t tw_cos(input logic [KW-1:0] k);
    case (int'(k))
      1:       return tword_t'(473);
      2:       return tword_t'(362);
      3:       return tword_t'(196);
      5:       return tword_t'(-196);
      6:       return tword_t'(-362);
      7:       return tword_t'(-473);
      default: return tword_t'(0);
    endcase
  endfunction

  // imaginary part of W16^k (that is -sin), scaled by 2^TFW
  function automatic tword_t tw_nsin(input logic [KW-1:0] k);
    case (int'(k))
      1, 7:    return tword_t'(-196);
      2, 6:    return tword_t'(-362);
      3, 5:    return tword_t'(-473);
      default: return tword_t'(0);
    endcase
  endfunction

endpackage

// File: rtl/sdf_cmul.sv
module sdf_cmul
  import sdf_fft_pkg::*;
(
  input  cplx_t  a,
  input  tword_t wr,
  input  tword_t wi,
  output cplx_t  y
);

  localparam int PW = DW + TW + 1;

  logic signed [PW-1:0] ar, ai, br, bi, pre, pim;

  assign ar  = a.re;
  assign ai  = a.im;
  assign br  = wr;
  assign bi  = wi;

  // four products, two adds
  assign pre = ar * br - ai * bi;
  assign pim = ar * bi + ai * br;

  // truncate toward minus infinity, then clamp to the data word
  assign y.re = sat_dw(int'(pre >>> TFW));
  assign y.im = sat_dw(int'(pim >>> TFW));

endmodule

// File: rtl/sdf_r2_stage.sv
module sdf_r2_stage
  import sdf_fft_pkg::*;
#(
  parameter int DELAY = 8
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  en,
  input  logic  in_v,
  input  cplx_t in_d,
  output logic  out_v,
  output cplx_t out_d
);

  localparam int CW    = $clog2(DELAY) + 1;
  localparam int KSTEP = NPT / (2 * DELAY);
  localparam rot_kind_e RK = (DELAY == 1) ? ROT_NONE :
                             (DELAY == 2) ? ROT_SWAP : ROT_FULL;

  logic [CW-1:0] cnt;
  logic          phase;
  logic          filled;
  logic          bf_v;
  cplx_t         dl [DELAY];
  cplx_t         head, bf, store, rot;

  assign phase = cnt[CW-1];
  assign head  = dl[DELAY-1];
  assign bf_v  = in_v & (phase | filled);

  // second half of a group: sum goes out, difference goes into the loop
  // first half: stored difference goes out, new sample goes into the loop
  always_comb begin
    if (phase) begin
      bf.re    = sat_dw(int'(head.re) + int'(in_d.re));
      bf.im    = sat_dw(int'(head.im) + int'(in_d.im));
      store.re = sat_dw(int'(head.re) - int'(in_d.re));
      store.im = sat_dw(int'(head.im) - int'(in_d.im));
    end else begin
      bf    = head;
      store = in_d;
    end
  end

  generate
    if (RK == ROT_NONE) begin : g_pass
      assign rot = bf;
    end else begin : g_rot
      logic [KW-1:0] k;
      assign k = phase ? '0 : KW'(int'(cnt[CW-2:0]) * KSTEP);
      if (RK == ROT_SWAP) begin : g_swap
        assign rot = (k == KW'(NPT / 4)) ? neg_j(bf) : bf;
      end else begin : g_full
        cplx_t prod;
        sdf_cmul u_mul (
          .a  (bf),
          .wr (tw_cos(k)),
          .wi (tw_nsin(k)),
          .y  (prod)
        );
        always_comb begin
          if (k == '0)                 rot = bf;
          else if (k == KW'(NPT / 4))  rot = neg_j(bf);
          else                         rot = prod;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      filled <= 1'b0;
      out_v  <= 1'b0;
      out_d  <= '0;
      for (int i = 0; i < DELAY; i++) dl[i] <= '0;
    end else begin
      if (en && in_v) begin
        dl[0] <= store;
        for (int i = 1; i < DELAY; i++) dl[i] <= dl[i-1];
        cnt <= cnt + CW'(1);
        if (phase) filled <= 1'b1;
      end
      if (en) begin
        out_v <= bf_v;
        out_d <= rot;
      end
    end
  end

endmodule

// File: rtl/sdf_fft16.sv
module sdf_fft16
  import sdf_fft_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic signed [DW-1:0] in_re,
  input  logic signed [DW-1:0] in_im,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic signed [DW-1:0] out_re,
  output logic signed [DW-1:0] out_im,
  output logic                 out_sof
);

  logic             step;
  logic             live_q;
  logic [LOG2N-1:0] slot_q;
  logic             sv [LOG2N+1];
  cplx_t            sd [LOG2N+1];

  assign step  = in_valid & in_ready;
  assign sv[0] = in_valid;
  assign sd[0] = '{re: in_re, im: in_im};

  generate
    for (genvar s = 0; s < LOG2N; s++) begin : g_stage
      sdf_r2_stage #(
        .DELAY (NPT >> (s + 1))
      ) u_stage (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (step),
        .in_v  (sv[s]),
        .in_d  (sd[s]),
        .out_v (sv[s+1]),
        .out_d (sd[s+1])
      );
    end
  endgenerate

  assign out_valid = sv[LOG2N] & live_q;
  assign in_ready  = ~out_valid | out_ready;
  assign out_re    = sd[LOG2N].re;
  assign out_im    = sd[LOG2N].im;
  assign out_sof   = out_valid & (slot_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q <= 1'b0;
      slot_q <= '0;
    end else begin
      if (step)           live_q <= 1'b1;
      else if (out_ready) live_q <= 1'b0;
      if (out_valid && out_ready) slot_q <= slot_q + LOG2N'(1);
    end
  end

endmodule

// File: rtl/sdf_fft16_chk.sv
module sdf_fft16_chk
  import sdf_fft_pkg::*;
(
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic                 in_ready,
  input logic                 out_valid,
  input logic                 out_ready,
  input logic signed [DW-1:0] out_re,
  input logic signed [DW-1:0] out_im,
  input logic                 out_sof
);

  localparam int AW = $clog2(FILL + 1) + 1;

  logic [AW-1:0] acc_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_n <= '0;
    else if (in_valid && in_ready && acc_n != '1) acc_n <= acc_n + AW'(1);
  end

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_re) && $stable(out_im) && $stable(out_sof)); // R2
  AST_STALL_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready); // R1
  AST_EMPTY_OPENS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready); // R1
  AST_FILL_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> acc_n >= AW'(FILL)); // R3
  AST_NEW_BIN_NEEDS_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(in_valid && in_ready)); // R3
  AST_DRAIN_WITHOUT_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !(in_valid && in_ready) |=> !out_valid); // R3
  AST_SOF_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    out_sof |-> out_valid); // R5

endmodule

bind sdf_fft16 sdf_fft16_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_re    (out_re),
  .out_im    (out_im),
  .out_sof   (out_sof)
);

// File: tb/sdf_fft16_test.sv
`timescale 1ns/1ps
module sdf_fft16_test;

  localparam int  NF_RAND  = 10;
  localparam int  WD_LIMIT = 20000;
  localparam real SQNR_MIN = 31.62; // 15 dB as a power ratio

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b0;
  logic signed [8:0] in_re = '0, in_im = '0;
  logic in_ready, out_valid, out_sof;
  logic signed [8:0] out_re, out_im;

  always #10 clk = ~clk;

  sdf_fft16 uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_re(in_re), .in_im(in_im), .out_valid(out_valid), .out_ready(out_ready),
    .out_re(out_re), .out_im(out_im), .out_sof(out_sof)
  );

  int n_chk = 0, n_bad = 0;
  int fin_re[$], fin_im[$];
  real ex_re[$], ex_im[$];
  int ex_kind[$];
  int n_frames = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  function automatic string tag(input int kind);
    case (kind)
      1: return "R8";
      2: return "R4";
      3: return "R7";
      default: return "R6";
    endcase
  endfunction

  function automatic int rev4(input int s);
    return ((s & 1) << 3) | ((s & 2) << 1) | ((s & 4) >> 1) | ((s & 8) >> 3);
  endfunction

  function automatic int rnd(input real v);
    return (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(-v + 0.5);
  endfunction

  // kinds: 0 exact (R6), 1 random (R8), 2 order (R4), 3 saturation (R7)
  task automatic add_frame(input int fr[16], input int fi[16], input int kind);
    for (int n = 0; n < 16; n++) begin
      fin_re.push_back(fr[n]);
      fin_im.push_back(fi[n]);
    end
    for (int s = 0; s < 16; s++) begin
      int k = rev4(s);
      real xr = 0.0, xi = 0.0;
      for (int n = 0; n < 16; n++) begin
        real th = -2.0 * 3.14159265358979 * k * n / 16.0;
        xr += fr[n] * $cos(th) - fi[n] * $sin(th);
        xi += fr[n] * $sin(th) + fi[n] * $cos(th);
      end
      if (xr > 255.0) xr = 255.0;
      if (xr < -256.0) xr = -256.0;
      if (xi > 255.0) xi = 255.0;
      if (xi < -256.0) xi = -256.0;
      ex_re.push_back(xr);
      ex_im.push_back(xi);
      ex_kind.push_back(kind);
    end
    n_frames++;
  endtask

  initial begin
    int fr[16], fi[16];
    int acc = 0, popped = 0, slot = 0, cyc = 0, target;
    bit seen_out = 0, hold_pend = 0, full_rate;
    logic signed [8:0] h_re, h_im;
    logic h_sof;
    real sig = 0.0, err = 0.0;

    // impulse at sample 0, A = 50
    for (int n = 0; n < 16; n++) begin fr[n] = 0; fi[n] = 0; end
    fr[0] = 50; add_frame(fr, fi, 0);
    // impulse at sample 8: even bins +A, odd bins -A
    fr[0] = 0; fr[8] = 40; fi[8] = -24; add_frame(fr, fi, 2);
    // constant (7, -3)
    for (int n = 0; n < 16; n++) begin fr[n] = 7; fi[n] = -3; end
    add_frame(fr, fi, 0);
    // constant (20, -20): bin 0 clamps
    for (int n = 0; n < 16; n++) begin fr[n] = 20; fi[n] = -20; end
    add_frame(fr, fi, 3);
    for (int f = 0; f < NF_RAND; f++) begin
      for (int n = 0; n < 16; n++) begin
        fr[n] = int'($urandom_range(20)) - 10;
        fi[n] = int'($urandom_range(20)) - 10;
      end
      add_frame(fr, fi, 1);
    end
    for (int n = 0; n < 16; n++) begin fr[n] = 0; fi[n] = 0; end
    for (int f = 0; f < 3; f++) add_frame(fr, fi, 0);
    target = 16 * (n_frames - 2);

    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R9", "out_valid in reset", int'(out_valid), 0);
    chk(in_ready == 1'b1, "R9", "in_ready in reset", int'(in_ready), 1);
    rst_n = 1'b1;

    while (popped < target && cyc < WD_LIMIT) begin
      @(negedge clk);
      cyc++;
      full_rate = (popped < 48);
      if (!seen_out && out_valid) begin
        seen_out = 1;
        chk(acc == 19, "R3", "accepted samples at first bin", acc, 19);
      end
      if (hold_pend) begin
        chk(out_valid === 1'b1, "R2", "valid held", int'(out_valid), 1);
        chk(out_re === h_re && out_im === h_im, "R2", "data held (re)", int'(out_re), int'(h_re));
        chk(out_sof === h_sof, "R2", "sof held", int'(out_sof), int'(h_sof));
      end
      in_valid = (fin_re.size() > 0) && (full_rate || ($urandom_range(3) != 0));
      if (fin_re.size() > 0) begin
        in_re = 9'(fin_re[0]);
        in_im = 9'(fin_im[0]);
      end
      out_ready = full_rate || ($urandom_range(9) < 7);
      #2;
      chk(in_ready == (!out_valid || out_ready), "R1", "ready rule", int'(in_ready),
          int'(!out_valid || out_ready));
      hold_pend = out_valid && !out_ready;
      h_re = out_re; h_im = out_im; h_sof = out_sof;
      if (in_valid && in_ready) begin
        void'(fin_re.pop_front());
        void'(fin_im.pop_front());
        acc++;
      end
      if (out_valid && out_ready) begin
        if (ex_re.size() == 0) begin
          chk(1'b0, "R3", "unexpected bin", popped, target);
        end else begin
          real er = ex_re.pop_front();
          real ei = ex_im.pop_front();
          int kind = ex_kind.pop_front();
          real tol = (kind == 1) ? 20.0 : 0.01;
          real dr = real'(out_re) - er;
          real di = real'(out_im) - ei;
          chk(dr <= tol && dr >= -tol, tag(kind), $sformatf("slot %0d re", slot), int'(out_re), rnd(er));
          chk(di <= tol && di >= -tol, tag(kind), $sformatf("slot %0d im", slot), int'(out_im), rnd(ei));
          chk(out_sof == (slot == 0), "R5", $sformatf("sof at slot %0d", slot), int'(out_sof),
              int'(slot == 0));
          sig += er * er + ei * ei;
          err += dr * dr + di * di;
          if (slot == 15) begin
            if (kind == 1)
              chk(err == 0.0 || sig >= SQNR_MIN * err, "R8", "frame SQNR x100",
                  (err == 0.0) ? 0 : rnd(100.0 * sig / err), rnd(100.0 * SQNR_MIN));
            sig = 0.0;
            err = 0.0;
          end
          slot = (slot + 1) % 16;
        end
        popped++;
      end
    end
    if (popped < target) chk(1'b0, "R3", "watchdog: bins received", popped, target);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule